// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM Model

This block is a synthesizable, cycle-level model of a pipelined synchronous SRAM. The memory is built so that a read and a write can follow each other on back-to-back clock cycles with no idle cycle on the shared data bus. On every rising edge the block decodes three chip enables (two active-low, one active-high), an advance/load control, a read/write select and active-low per-lane write enables. From these it starts a burst, continues a burst, or does nothing. Bursts step through four words using a 2-bit counter. The counter wraps inside an aligned group of four words.

A read address taken at one enabled edge has its data driven out of a register at the next enabled edge, so the host samples it at the second enabled edge. Write data for an address taken at one enabled edge is sampled from the input bus at the second enabled edge, and it is committed to the array at that edge. A read that hits a write still waiting in the pipeline returns the newer data, merged lane by lane. A high clock-hold input freezes the whole pipeline. The output enable and sleep inputs act on the bus drive asynchronously.

The tristate bus is split into three plain signals: write data in, read data out, and a drive flag. Each lane is `LANE_W` bits wide. Lane `i` occupies bits `[i*LANE_W +: LANE_W]`.

Top module: `nbt_sram`

## Requirements
- R1: After synchronous reset `bus_drive` is 0, and it stays 0 until a read has been issued and has passed through the pipeline.
- R2: An enabled edge with `advance`=0 and any of `en_a_n`=1, `en_b_n`=1 or `en_c`=0 is a deselect. It issues no operation, so one enabled edge later `bus_drive` is 0.
- R3: An enabled edge with `advance`=0, all enables active and `rd_wr`=1 starts a read burst at `addr`. The word appears on `rdata` with `bus_drive`=1 after the next enabled edge, and holds until the edge after that.
- R4: An enabled edge with `advance`=0, all enables active and `rd_wr`=0 starts a write burst. `wdata` is sampled at the second enabled edge after each address edge. Only lanes whose `lane_wr_n` bit was 0 at the address edge are written.
- R5: A write cycle with every `lane_wr_n` bit at 1 changes no array word, but it still advances the burst.
- R6: With `advance`=1 after a begin-burst, the operation type of that burst continues and the chip enables and `rd_wr` are ignored. The n-th continue cycle uses address `{start[ADDR_W-1:2], start[1:0]+n}`, wrapping every four cycles.
- R7: With `advance`=1 after a deselect or after reset, the block stays deselected and issues nothing.
- R8: A read whose data slot falls while `out_en_n`=1 drives nothing, but the burst address still advances.
- R9: `bus_drive` follows `out_en_n` without waiting for a clock edge. It is 1 only while read data is held and `out_en_n`=0.
- R10: An edge with `clk_hold`=1 is ignored. Read data and the drive state are held, and no write is committed on that edge.
- R11: `sleep`=1 forces `bus_drive` to 0 at once and makes clock edges ignored. When `sleep` returns to 0, the pipeline resumes from its held state.
- R12: `bus_drive` is 0 during every write data cycle, whatever the level of `out_en_n`.
- R13: A read whose address equals that of one or two earlier writes not yet committed returns the newer write data in each lane that those writes enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_a_n | input | 1 | Chip enable, active low |
| en_b_n | input | 1 | Second chip enable, active low |
| en_c | input | 1 | Third chip enable, active high |
| advance | input | 1 | 1 = continue burst, 0 = load new command |
| rd_wr | input | 1 | 1 = read, 0 = write (begin-burst only) |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| clk_hold | input | 1 | 1 = ignore this clock edge |
| sleep | input | 1 | Asynchronous sleep, forces bus off and freezes state |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data from the bus |
| rdata | output | LANES*LANE_W | Registered read data |
| bus_drive | output | 1 | 1 when the block drives the data bus |

## Verification
The assertions take for granted that `clk_hold` and `sleep` are the only ways an edge is skipped. They also assume `out_en_n` and `sleep` change away from the clock edge, so that sampling them at an edge sees a settled drive flag. The bench changes every input one time unit after a rising edge, and it issues continue cycles only with the enables and `rd_wr` deliberately set to illegal values, to show that they are ignored. Reads target only addresses the bench has already written, so the checked data never depends on the array's unreset contents.

// File: rtl/nbt_sram_pkg.sv
`timescale 1ns/1ps
package nbt_sram_pkg;
  // Width of the wrapping burst counter (four-beat bursts).
  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    BM_IDLE  = 2'd0,
    BM_READ  = 2'd1,
    BM_WRITE = 2'd2
  } burst_mode_e;
endpackage

// File: rtl/nbt_sram_cmd.sv
`timescale 1ns/1ps
module nbt_sram_cmd
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  input  logic              advance,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              op_valid,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_lanes,
  output burst_mode_e       mode
);
  localparam int CW = BURST_BITS;

  burst_mode_e       mode_q, mode_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              unsel;

  always_comb begin
    unsel    = en_a_n | en_b_n | ~en_c;
    mode_n   = mode_q;
    base_n   = base_q;
    cnt_n    = cnt_q;
    op_valid = 1'b0;
    op_wr    = 1'b0;
    op_addr  = addr;
    op_lanes = ~lane_wr_n;
    if (!advance) begin
      if (unsel) begin
        mode_n = BM_IDLE;
      end else begin
        mode_n   = rd_wr ? BM_READ : BM_WRITE;
        base_n   = addr;
        cnt_n    = '0;
        op_valid = 1'b1;
        op_wr    = ~rd_wr;
      end
    end else if (mode_q != BM_IDLE) begin
      cnt_n    = cnt_q + 1'b1;
      op_valid = 1'b1;
      op_wr    = (mode_q == BM_WRITE);
      op_addr  = {base_q[ADDR_W-1:CW], base_q[CW-1:0] + cnt_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= BM_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      mode_q <= mode_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/nbt_sram_array.sv
`timescale 1ns/1ps
module nbt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // One narrow memory per lane keeps each a plain simple-dual-port RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en)       q <= mem[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/nbt_sram_merge.sv
`timescale 1ns/1ps
module nbt_sram_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic [LANES*LANE_W-1:0] base,
  input  logic [LANES*LANE_W-1:0] upd,
  input  logic [LANES-1:0]        take,
  output logic [LANES*LANE_W-1:0] result
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign result[g*LANE_W +: LANE_W] =
      take[g] ? upd[g*LANE_W +: LANE_W] : base[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_a_n,
  input  logic                    en_b_n,
  input  logic                    en_c,
  input  logic                    advance,
  input  logic                    rd_wr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    clk_hold,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive
);
  localparam int DW = LANES * LANE_W;

  logic step;
  assign step = ~clk_hold & ~sleep;

  // Command decode and burst sequencing
  logic              op_valid, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_lanes;
  burst_mode_e       burst_mode;

  nbt_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst(rst), .step(step),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .advance(advance), .rd_wr(rd_wr), .addr(addr), .lane_wr_n(lane_wr_n),
    .op_valid(op_valid), .op_wr(op_wr), .op_addr(op_addr),
    .op_lanes(op_lanes), .mode(burst_mode)
  );

  // Two pipeline stages: s1 = one edge past address, s2 = data edge next.
  logic              s1_valid, s1_wr, s2_valid, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_lanes, s2_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (step) begin
      s1_valid <= op_valid;
      s1_wr    <= op_wr;
      s1_addr  <= op_addr;
      s1_lanes <= op_lanes;
      s2_valid <= s1_valid;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  // Array: write commits from s2 with the bus data of this edge.
  logic           s2_is_wr;
  logic [LANES-1:0] commit_lanes;
  logic [DW-1:0]  ram_q;
  logic           rd_issue;

  assign s2_is_wr     = s2_valid & s2_wr;
  assign commit_lanes = (step & s2_is_wr) ? s2_lanes : '0;
  assign rd_issue     = step & op_valid & ~op_wr;

  nbt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(rd_issue), .rd_addr(op_addr), .rd_data(ram_q),
    .wr_lanes(commit_lanes), .wr_addr(s2_addr), .wr_data(wdata)
  );

  // Older hazard: write committing on the same edge as the array read.
  logic             fa_hit;
  logic [LANES-1:0] fa_lanes;
  logic [DW-1:0]    fa_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_hit   <= 1'b0;
      fa_lanes <= '0;
      fa_data  <= '0;
    end else if (step) begin
      fa_hit   <= s2_is_wr & (s2_addr == op_addr);
      fa_lanes <= s2_lanes;
      fa_data  <= wdata;
    end
  end

  // Newer hazard: write whose data arrives on the output edge.
  logic             fb_hit;
  logic [LANES-1:0] take_a, take_b;
  logic [DW-1:0]    merged_a, merged_b;

  assign fb_hit = s2_is_wr & (s2_addr == s1_addr);
  assign take_a = fa_hit ? fa_lanes : '0;
  assign take_b = fb_hit ? s2_lanes : '0;

  nbt_sram_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_old (
    .base(ram_q), .upd(fa_data), .take(take_a), .result(merged_a)
  );
  nbt_sram_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_new (
    .base(merged_a), .upd(wdata), .take(take_b), .result(merged_b)
  );

  // Output register and drive control
  logic          drive_q;
  logic [DW-1:0] rdata_q;
  logic          s1_is_rd;

  assign s1_is_rd = s1_valid & ~s1_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else if (step) begin
      drive_q <= s1_is_rd;
      if (s1_is_rd) rdata_q <= merged_b;
    end
  end

  assign rdata     = rdata_q;
  assign bus_drive = drive_q & ~out_en_n & ~sleep;
endmodule

// File: rtl/nbt_sram_chk.sv
`timescale 1ns/1ps
module nbt_sram_chk
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DW     = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              en_a_n,
  input logic              en_b_n,
  input logic              en_c,
  input logic              advance,
  input logic              out_en_n,
  input logic              sleep,
  input logic              bus_drive,
  input logic [DW-1:0]     rdata,
  input burst_mode_e       burst_mode,
  input logic              s1_valid,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_valid,
  input logic              s2_wr
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !bus_drive); // R1
  AST_DESEL_NOOP: assert property (@(posedge clk) disable iff (rst) (step && !advance && (en_a_n || en_b_n || !en_c)) |=> !s1_valid); // R2
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst) (step && advance && burst_mode != BM_IDLE) |=> ((s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1) && (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])))); // R6
  AST_CONT_DESEL: assert property (@(posedge clk) disable iff (rst) (step && advance && burst_mode == BM_IDLE) |=> !s1_valid); // R7
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst) out_en_n |-> !bus_drive); // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(rdata)); // R10
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst) sleep |-> !bus_drive); // R11
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst) (s2_valid && s2_wr) |-> !bus_drive); // R12
endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .en_a_n(en_a_n), .en_b_n(en_b_n),
  .en_c(en_c), .advance(advance), .out_en_n(out_en_n), .sleep(sleep),
  .bus_drive(bus_drive), .rdata(rdata), .burst_mode(burst_mode),
  .s1_valid(s1_valid), .s1_addr(s1_addr), .s2_valid(s2_valid), .s2_wr(s2_wr)
);

// File: tb/sim_nbt_sram.sv
`timescale 1ns/1ps
module sim_nbt_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_a_n = 1'b1, en_b_n = 1'b0, en_c = 1'b1;
  logic          advance = 1'b0, rd_wr = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          out_en_n = 1'b0, clk_hold = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          bus_drive;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [DW-1:0] ref_mem [1<<AW];

  always #2 clk = ~clk; // 250 MHz

  nbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .advance(advance), .rd_wr(rd_wr), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .clk_hold(clk_hold), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bus_drive(bus_drive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input int i);
    baddr = {s[AW-1:2], s[1:0] + 2'(i)};
  endfunction

  function automatic logic [DW-1:0] pat(input logic [DW-1:0] seed, input int i);
    pat = seed + DW'(i) * 36'h0_1357_9BDF;
  endfunction

  function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [NL-1:0] ln_n);
    lane_mix = old;
    for (int k = 0; k < NL; k++)
      if (!ln_n[k]) lane_mix[k*LW +: LW] = nw[k*LW +: LW];
  endfunction

  task automatic drv_begin(input bit rd, input logic [AW-1:0] a, input logic [NL-1:0] ln_n);
    advance = 1'b0; en_a_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1;
    rd_wr = rd; addr = a; lane_wr_n = ln_n;
  endtask

  // Continue cycle with enables and rd_wr set to values that must be ignored.
  task automatic drv_cont(input logic [NL-1:0] ln_n);
    advance = 1'b1; en_a_n = 1'b1; en_b_n = 1'b1; en_c = 1'b0;
    rd_wr = ~rd_wr; addr = ~addr; lane_wr_n = ln_n;
  endtask

  task automatic drv_desel();
    advance = 1'b0; en_a_n = 1'b1; en_b_n = 1'b0; en_c = 1'b1;
    lane_wr_n = '1;
  endtask

  task automatic write_burst(input logic [AW-1:0] start, input int n, input logic [NL-1:0] ln_n, input logic [DW-1:0] seed);
    for (int i = 0; i < n + 2; i++) begin
      if (i == 0) drv_begin(1'b0, start, ln_n);
      else if (i < n) drv_cont(ln_n);
      else drv_desel();
      if (i >= 2) wdata = pat(seed, i - 2);
      tick();
      if (i >= 1 && i <= n) check(!bus_drive, "R12 bus off in write data cycle", DW'(bus_drive), '0);
    end
    for (int i = 0; i < n; i++)
      ref_mem[baddr(start, i)] = lane_mix(ref_mem[baddr(start, i)], pat(seed, i), ln_n);
  endtask

  task automatic read_burst(input logic [AW-1:0] start, input int n, input string req);
    for (int i = 0; i <= n; i++) begin
      if (i == 0) drv_begin(1'b1, start, '1);
      else if (i < n) drv_cont('1);
      else drv_desel();
      tick();
      if (i >= 1) begin
        check(bus_drive, {req, " R3 drive on read"}, DW'(bus_drive), DW'(1));
        check(rdata === ref_mem[baddr(start, i - 1)], {req, " R3 read data"}, rdata, ref_mem[baddr(start, i - 1)]);
      end
    end
    drv_desel();
    tick();
    check(!bus_drive, {req, " R2 bus off after deselect"}, DW'(bus_drive), '0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check(!bus_drive, "R1 bus off after reset", DW'(bus_drive), '0);
    drv_cont('1);
    tick();
    tick();
    check(!bus_drive, "R7 continue-deselect after reset", DW'(bus_drive), '0);
    check(!bus_drive && rdata == '0, "R1 no data before first read", rdata, '0);
  endtask

  task automatic t_burst();
    write_burst(6'd10, 4, 4'b0000, 36'h1_0203_0405);
    read_burst(6'd8, 5, "R6 wrap");
    write_burst(6'd8, 1, 4'b0000, 36'h9_8765_4321);
    read_burst(6'd8, 4, "R6 linear");
  endtask

  task automatic t_lanes();
    write_burst(6'd20, 1, 4'b0000, 36'h0_AAAA_5555);
    write_burst(6'd20, 1, 4'b1010, 36'hF_0F0F_0F0F);
    read_burst(6'd20, 1, "R4 lane mask");
    write_burst(6'd20, 1, 4'b1111, 36'h3_3333_3333);
    read_burst(6'd20, 1, "R5 write abort");
  endtask

  task automatic t_desel();
    for (int k = 0; k < 3; k++) begin
      drv_begin(1'b1, 6'd8, '1);
      tick();
      drv_begin(1'b1, 6'd9, '1);
      if (k == 0) en_a_n = 1'b1;
      else if (k == 1) en_b_n = 1'b1;
      else en_c = 1'b0;
      tick();
      check(bus_drive && rdata === ref_mem[8], "R3 read before deselect", rdata, ref_mem[8]);
      drv_desel();
      tick();
      check(!bus_drive, "R2 deselect by each enable", DW'(bus_drive), '0);
    end
    drv_cont('1);
    tick();
    tick();
    check(!bus_drive, "R7 continue-deselect", DW'(bus_drive), '0);
  endtask

  task automatic t_dummy();
    out_en_n = 1'b1;
    drv_begin(1'b1, 6'd8, '1);
    tick();
    drv_cont('1);
    tick();
    check(!bus_drive, "R8 dummy read drives nothing", DW'(bus_drive), '0);
    out_en_n = 1'b0;
    #1;
    check(bus_drive && rdata === ref_mem[8], "R9 async output enable", rdata, ref_mem[8]);
    out_en_n = 1'b1;
    #1;
    check(!bus_drive, "R9 async output disable", DW'(bus_drive), '0);
    drv_desel();
    tick();
    out_en_n = 1'b0;
    #1;
    check(bus_drive && rdata === ref_mem[9], "R8 burst advanced during dummy read", rdata, ref_mem[9]);
    tick();
  endtask

  task automatic t_stall();
    drv_begin(1'b1, 6'd8, '1);
    tick();
    drv_cont('1);
    tick();
    clk_hold = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(bus_drive && rdata === ref_mem[8], "R10 stall holds read", rdata, ref_mem[8]);
    end
    clk_hold = 1'b0;
    drv_desel();
    tick();
    check(bus_drive && rdata === ref_mem[9], "R10 burst resumes after stall", rdata, ref_mem[9]);
    tick();
    // write whose data edge is stalled
    drv_begin(1'b0, 6'd40, 4'b0000);
    tick();
    drv_desel();
    tick();
    clk_hold = 1'b1;
    wdata = 36'hB_ADBA_DBAD;
    tick();
    tick();
    check(!bus_drive, "R10 stalled write keeps bus off", DW'(bus_drive), '0);
    clk_hold = 1'b0;
    wdata = 36'h6_0D06_0D06;
    tick();
    ref_mem[40] = 36'h6_0D06_0D06;
    read_burst(6'd40, 1, "R10 no write on held edge");
  endtask

  task automatic t_sleep();
    drv_begin(1'b1, 6'd8, '1);
    tick();
    drv_cont('1);
    tick();
    sleep = 1'b1;
    #1;
    check(!bus_drive, "R11 sleep forces bus off", DW'(bus_drive), '0);
    drv_begin(1'b1, 6'd20, '1);
    tick();
    tick();
    sleep = 1'b0;
    drv_desel();
    #1;
    check(bus_drive && rdata === ref_mem[8], "R11 state held during sleep", rdata, ref_mem[8]);
    tick();
    check(bus_drive && rdata === ref_mem[9], "R11 pipeline resumes after sleep", rdata, ref_mem[9]);
    tick();
  endtask

  task automatic t_forward();
    logic [DW-1:0] w1, w2;
    w1 = 36'hC_AFE0_1234;
    w2 = 36'h5_5AA5_A55A;
    drv_begin(1'b0, 6'd30, 4'b0000);
    tick();
    drv_begin(1'b1, 6'd30, '1);
    tick();
    check(!bus_drive, "R12 write slot not driven", DW'(bus_drive), '0);
    drv_desel();
    wdata = w1;
    tick();
    check(bus_drive && rdata === w1, "R13 read follows write at once", rdata, w1);
    ref_mem[30] = w1;
    tick();
    drv_begin(1'b0, 6'd30, 4'b0011);
    tick();
    drv_desel();
    tick();
    drv_begin(1'b1, 6'd30, '1);
    wdata = w2;
    tick();
    drv_desel();
    tick();
    ref_mem[30] = lane_mix(w1, w2, 4'b0011);
    check(bus_drive && rdata === ref_mem[30], "R13 read merges committing write", rdata, ref_mem[30]);
    tick();
    read_burst(6'd30, 1, "R13 array holds merged word");
  endtask

  initial begin
    t_reset();
    t_burst();
    t_lanes();
    t_desel();
    t_dummy();
    t_stall();
    t_sleep();
    t_forward();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule